// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block is the digital fault supervisor of a fixed-frequency step-down regulator. Each regulator period it watches two things: whether the high-side switch was turned on, and whether that turn-on ran into the peak current limit. A limit hit ends the high-side conduction for the rest of the period and hands the period to the low-side switch. Persistent limit hits are counted. When the eighth one lands before the count has been cleared, the controller shuts both switches off, holds the soft-start node in discharge, and waits a fixed number of regulator periods. It then issues a one-cycle restart pulse that launches a new soft-start.

A separate thermal-fault input, already filtered for hysteresis, overrides all of this. While the fault is present, both switches are held off and soft-start is held discharged. When the fault clears, the controller restarts through the same restart pulse. Protection is armed from the first cycle after a restart, so an overload during soft-start trips the controller just as it would in steady regulation. All signals are plain control strobes and levels. There is no data stream, so there is no valid/ready handshake.

A regulator period is the span that ends with a cycle in which `period_tick` is high. Turn-on and limit strobes seen in that closing cycle belong to the period that is ending.

Top module: `hiccup_guard`

## Requirements
- R1: After reset, `hs_kill`, `sw_force_off`, `ss_discharge` and `ss_restart` are all low, and the controller is in normal run with both counters at zero.
- R2: In run, a cycle with `ilim_hit` high and `period_tick` low raises `hs_kill` from the next cycle until the cycle after the period's closing tick. While `hs_kill` is high, `sw_force_off` stays low, so the low-side switch carries the rest of the period.
- R3: A period that contains at least one `ilim_hit` counts as one limit event in a 3-bit counter. When the eighth event closes, `sw_force_off` and `ss_discharge` go high in the next cycle.
- R4: A period with a turn-on (`hs_on`) and no limit is clean. Three consecutive clean periods clear the event count. A limit period clears the clean run. A period with neither turn-on nor limit changes neither count.
- R5: The event counter never wraps: seven events followed by three clean periods, then seven more events, give no shutdown.
- R6: Once a limit-count shutdown starts, `sw_force_off` and `ss_discharge` stay high until HICCUP_PERIODS (default 1024) further ticks have been seen. The restart pulse appears in the cycle after that last tick.
- R7: `ss_restart` is high for exactly one cycle, with `sw_force_off` still high. The next cycle returns to run with both counters cleared, and limit counting is active at once.
- R8: A `therm_fault` high in any state gives `sw_force_off` and `ss_discharge` high in the next cycle and holds them while the fault stays. The fault takes priority over a hiccup wait or a trip in the same cycle. The cycle after the fault clears, `ss_restart` pulses.
- R9: Outside run, `hs_on` and `ilim_hit` are ignored: `hs_kill` stays low and they add nothing to the count seen after restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_tick | input | 1 | One-cycle strobe closing each regulator period |
| hs_on | input | 1 | High-side turn-on strobe for the current period |
| ilim_hit | input | 1 | High-side peak current limit reached |
| therm_fault | input | 1 | Over-temperature fault, hysteresis already applied |
| hs_kill | output | 1 | Ends high-side conduction for the rest of the period (low-side takes over) |
| sw_force_off | output | 1 | Holds both power switches off |
| ss_discharge | output | 1 | Requests discharge of the soft-start node |
| ss_restart | output | 1 | One-cycle pulse that begins a new soft-start |

## Verification
Several corner cases are driven on purpose. Seven limit periods, then three clean periods, then seven more must not trip; a design that keeps the count or wraps it would shut down early or miss the real eighth event. Two clean periods broken by a limit period, and idle periods with no turn-on, must leave the count standing; a design that clears on the first clean pulse would never trip under an intermittent overload. The hiccup wait is timed to the exact tick, so an off-by-one wait moves the restart pulse by a full period. A thermal fault arriving during a hiccup wait, and limit strobes during the wait, show whether the fault has priority and whether the counters leak events into the next soft-start.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_THERM   = 2'd2,
    ST_RESTART = 2'd3
  } hg_state_t;
endpackage

// File: rtl/hg_period_monitor.sv
// Classifies each regulator period as limited, clean or idle and drives the
// per-period high-side termination.
module hg_period_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic period_tick,
  input  logic hs_on,
  input  logic ilim_hit,
  output logic close_lim,
  output logic close_clean,
  output logic hs_kill
);
  logic lim_seen, on_seen, kill_q;
  logic lim_any, on_any;

  assign lim_any     = lim_seen | ilim_hit;
  assign on_any      = on_seen  | hs_on;
  assign close_lim   = active & period_tick & lim_any;
  assign close_clean = active & period_tick & on_any & ~lim_any;
  assign hs_kill     = kill_q & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_seen <= 1'b0;
      on_seen  <= 1'b0;
      kill_q   <= 1'b0;
    end else if (!active || period_tick) begin
      lim_seen <= 1'b0;
      on_seen  <= 1'b0;
      kill_q   <= 1'b0;
    end else begin
      lim_seen <= lim_any;
      on_seen  <= on_any;
      if (ilim_hit) kill_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hg_event_counter.sv
// Limit-event counter with a clean-run counter that clears it.
module hg_event_counter #(
  parameter int EVT_W     = 3,
  parameter int CLEAN_RUN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             close_lim,
  input  logic             close_clean,
  output logic             trip,
  output logic [EVT_W-1:0] evt_count
);
  localparam int CLEAN_W = (CLEAN_RUN > 1) ? $clog2(CLEAN_RUN) : 1;
  localparam logic [CLEAN_W-1:0] CLEAN_LAST = CLEAN_W'(CLEAN_RUN - 1);

  logic [CLEAN_W-1:0] clean_q;
  logic [EVT_W:0]     evt_sum;

  // The carry out of the increment marks the final event; the count saturates.
  assign evt_sum = {1'b0, evt_count} + {{EVT_W{1'b0}}, 1'b1};
  assign trip    = close_lim & evt_sum[EVT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_count <= '0;
      clean_q   <= '0;
    end else if (clear) begin
      evt_count <= '0;
      clean_q   <= '0;
    end else if (close_lim) begin
      if (!evt_sum[EVT_W]) evt_count <= evt_sum[EVT_W-1:0];
      clean_q <= '0;
    end else if (close_clean) begin
      if (clean_q == CLEAN_LAST) begin
        evt_count <= '0;
        clean_q   <= '0;
      end else begin
        clean_q <= clean_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hg_wait_timer.sv
// Counts regulator periods during the hiccup wait.
module hg_wait_timer #(
  parameter int WAIT_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic period_tick,
  output logic done
);
  localparam int WAIT_W = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_TICKS - 1);

  logic [WAIT_W-1:0] cnt_q;

  assign done = active & period_tick & (cnt_q == WAIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!active)      cnt_q <= '0;
    else if (period_tick)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hg_fsm.sv
// Protection state machine; thermal fault outranks everything.
module hg_fsm
  import hiccup_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      therm_fault,
  input  logic      trip,
  input  logic      wait_done,
  output hg_state_t state
);
  hg_state_t nxt;

  always_comb begin
    nxt = state;
    if (therm_fault) begin
      nxt = ST_THERM;
    end else begin
      unique case (state)
        ST_RUN:     if (trip)      nxt = ST_WAIT;
        ST_WAIT:    if (wait_done) nxt = ST_RESTART;
        ST_THERM:   nxt = ST_RESTART;
        ST_RESTART: nxt = ST_RUN;
        default:    nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_pkg::*;
#(
  parameter int EVT_W          = 3,
  parameter int CLEAN_RUN      = 3,
  parameter int HICCUP_PERIODS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_tick,
  input  logic hs_on,
  input  logic ilim_hit,
  input  logic therm_fault,
  output logic hs_kill,
  output logic sw_force_off,
  output logic ss_discharge,
  output logic ss_restart
);
  hg_state_t        state;
  logic             run_q, close_lim, close_clean, trip, wait_done;
  logic [EVT_W-1:0] evt_count;

  assign run_q = (state == ST_RUN);

  hg_period_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .active(run_q), .period_tick(period_tick),
    .hs_on(hs_on), .ilim_hit(ilim_hit), .close_lim(close_lim),
    .close_clean(close_clean), .hs_kill(hs_kill)
  );

  hg_event_counter #(.EVT_W(EVT_W), .CLEAN_RUN(CLEAN_RUN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_RESTART),
    .close_lim(close_lim), .close_clean(close_clean),
    .trip(trip), .evt_count(evt_count)
  );

  hg_wait_timer #(.WAIT_TICKS(HICCUP_PERIODS)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(state == ST_WAIT),
    .period_tick(period_tick), .done(wait_done)
  );

  hg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .therm_fault(therm_fault),
    .trip(trip), .wait_done(wait_done), .state(state)
  );

  assign sw_force_off = ~run_q;
  assign ss_discharge = (state == ST_WAIT) | (state == ST_THERM);
  assign ss_restart   = (state == ST_RESTART);
endmodule

// File: rtl/hg_checker.sv
module hg_checker #(
  parameter int EVT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             period_tick,
  input logic             therm_fault,
  input logic             hs_kill,
  input logic             sw_force_off,
  input logic             ss_discharge,
  input logic             ss_restart,
  input logic [EVT_W-1:0] evt_count
);
  AST_KILL_KEEPS_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_kill |-> !sw_force_off); // R2
  AST_KILL_ENDS_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !hs_kill); // R2
  AST_DISCHARGE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ss_discharge |-> sw_force_off); // R6
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart); // R7
  AST_RESTART_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> sw_force_off && !ss_discharge); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> evt_count == '0); // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_restart && !therm_fault) |=> !sw_force_off); // R7
  AST_THERMAL_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    therm_fault |=> (sw_force_off && ss_discharge)); // R8
endmodule

bind hiccup_guard hg_checker #(.EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .therm_fault(therm_fault),
  .hs_kill(hs_kill), .sw_force_off(sw_force_off), .ss_discharge(ss_discharge),
  .ss_restart(ss_restart), .evt_count(evt_count)
);

// File: tb/hiccup_guard_tb.sv
module hiccup_guard_tb;
  localparam int WAITP = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_tick = 1'b0, hs_on = 1'b0, ilim_hit = 1'b0, therm_fault = 1'b0;
  logic hs_kill, sw_force_off, ss_discharge, ss_restart;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state (0 run, 1 wait, 2 thermal, 3 restart)
  int m_st = 0, m_evt = 0, m_clean = 0, m_wait = 0;
  bit m_lim = 0, m_on = 0, m_kill = 0;
  int disch_cycles = 0, restart_cycles = 0;

  always #4 clk = ~clk;

  hiccup_guard u_dut (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .hs_on(hs_on),
    .ilim_hit(ilim_hit), .therm_fault(therm_fault), .hs_kill(hs_kill),
    .sw_force_off(sw_force_off), .ss_discharge(ss_discharge), .ss_restart(ss_restart)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_step(bit tk, bit on, bit lim, bit th);
    bit run, lim_any, c_lim, c_clean, trip, wdone;
    int nst;
    run = (m_st == 0);
    lim_any = m_lim | lim;
    c_lim = run & tk & lim_any;
    c_clean = run & tk & (m_on | on) & !lim_any;
    trip = c_lim && (m_evt == 7);
    wdone = (m_st == 1) && tk && (m_wait == WAITP - 1);
    if (th) nst = 2;
    else case (m_st)
      0: nst = trip ? 1 : 0;
      1: nst = wdone ? 3 : 1;
      2: nst = 3;
      default: nst = 0;
    endcase
    if (m_st == 3) begin m_evt = 0; m_clean = 0; end
    else if (c_lim) begin if (m_evt < 7) m_evt++; m_clean = 0; end
    else if (c_clean) begin
      if (m_clean == 2) begin m_evt = 0; m_clean = 0; end else m_clean++;
    end
    if (m_st != 1) m_wait = 0; else if (tk) m_wait++;
    if (!run || tk) begin m_lim = 0; m_on = 0; m_kill = 0; end
    else begin m_lim = lim_any; m_on = m_on | on; if (lim) m_kill = 1; end
    m_st = nst;
  endfunction

  task automatic cyc(input bit tk, input bit on, input bit lim, input bit th, input string tag);
    period_tick = tk; hs_on = on; ilim_hit = lim; therm_fault = th;
    @(posedge clk);
    model_step(tk, on, lim, th);
    @(negedge clk);
    check(tag, "hs_kill", hs_kill, m_kill && (m_st == 0));
    check(tag, "sw_force_off", sw_force_off, m_st != 0);
    check(tag, "ss_discharge", ss_discharge, (m_st == 1) || (m_st == 2));
    check(tag, "ss_restart", ss_restart, m_st == 3);
    if (ss_discharge) disch_cycles++;
    if (ss_restart) restart_cycles++;
  endtask

  // one regulator period of four clocks: turn-on, limit slot, idle, tick
  task automatic period(input bit on, input bit lim, input bit th, input string tag);
    cyc(0, on, 0, th, tag);
    cyc(0, 0, lim, th, tag);
    cyc(0, 0, 0, th, tag);
    cyc(1, 0, 0, th, tag);
  endtask

  task automatic wait_restart(input string tag);
    for (int i = 0; i < 4 * WAITP + 8 && !ss_restart; i++) cyc(i % 4 == 3, 0, 0, 0, tag);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1f2e3d4c);
    @(negedge clk);
    check("R1", "hs_kill@rst", hs_kill, 1'b0);
    check("R1", "force@rst", sw_force_off, 1'b0);
    check("R1", "disch@rst", ss_discharge, 1'b0);
    check("R1", "restart@rst", ss_restart, 1'b0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, "R1");

    // R2: limit in the middle of a period kills high side until the tick
    cyc(0, 1, 0, 0, "R2");
    cyc(0, 0, 1, 0, "R2");
    check("R2", "kill raised", hs_kill, 1'b1);
    check("R2", "low side kept", sw_force_off, 1'b0);
    cyc(0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    check("R2", "kill cleared", hs_kill, 1'b0);
    for (int i = 0; i < 3; i++) period(1, 0, 0, "R4");

    // R3: eight limit periods trip
    for (int i = 0; i < 7; i++) period(1, 1, 0, "R3");
    check("R3", "no trip at 7", sw_force_off, 1'b0);
    period(1, 1, 0, "R3");
    check("R3", "trip force", sw_force_off, 1'b1);
    check("R3", "trip disch", ss_discharge, 1'b1);

    // R6/R9: exact wait, limits ignored during it
    disch_cycles = 1;
    restart_cycles = 0;
    for (int i = 0; i < 20; i++) period(1, 1, 0, "R9");
    check("R9", "kill idle in wait", hs_kill, 1'b0);
    wait_restart("R6");
    check("R6", "disch length ok", disch_cycles == 4 * WAITP, 1'b1);
    check("R7", "restart seen", ss_restart, 1'b1);
    cyc(0, 0, 0, 0, "R7");
    check("R7", "restart one cycle", ss_restart, 1'b0);
    check("R7", "rearm", sw_force_off, 1'b0);
    // armed immediately: seven limits after restart do not trip (fresh count), eighth does
    for (int i = 0; i < 7; i++) period(1, 1, 0, "R9");
    check("R9", "fresh count", sw_force_off, 1'b0);
    period(1, 1, 0, "R7");
    check("R7", "trip in soft-start", sw_force_off, 1'b1);

    // R8: thermal during hiccup wait takes over, then restarts
    for (int i = 0; i < 5; i++) period(0, 0, 0, "R8");
    period(0, 0, 1, "R8");
    check("R8", "thermal disch", ss_discharge, 1'b1);
    cyc(0, 0, 0, 0, "R8");
    check("R8", "restart after fault", ss_restart, 1'b1);
    cyc(0, 0, 0, 0, "R8");
    check("R8", "back to run", sw_force_off, 1'b0);

    // R4/R5: 7 limits, 3 clean, 7 limits: no trip
    for (int i = 0; i < 7; i++) period(1, 1, 0, "R5");
    for (int i = 0; i < 3; i++) period(1, 0, 0, "R4");
    for (int i = 0; i < 7; i++) period(1, 1, 0, "R5");
    check("R5", "no wrap trip", sw_force_off, 1'b0);
    // broken clean runs and idle periods keep the count: one more limit trips
    period(1, 0, 0, "R4"); period(1, 0, 0, "R4"); period(1, 1, 0, "R4");
    check("R4", "limit trips at 8", sw_force_off, 1'b1);
    wait_restart("R6");
    cyc(0, 0, 0, 0, "R7");
    for (int i = 0; i < 7; i++) period(1, 1, 0, "R4");
    period(1, 0, 0, "R4"); period(0, 0, 0, "R4"); period(1, 0, 0, "R4");
    period(1, 1, 0, "R4");
    check("R4", "idle keeps count", sw_force_off, 1'b1);
    wait_restart("R6");
    cyc(0, 0, 0, 0, "R7");

    // constrained random with varying overload density
    for (int blk = 0; blk < 3; blk++) begin
      int pct = (blk == 0) ? 10 : ((blk == 1) ? 45 : 85);
      int th_left = 0;
      for (int p = 0; p < 1500; p++) begin
        bit on = ($urandom % 4) != 0;
        bit lim = ($urandom % 100) < pct;
        if (th_left == 0 && ($urandom % 400) == 0) th_left = 1 + $urandom % 6;
        for (int c = 0; c < 4; c++) begin
          bit th = th_left > 0;
          cyc(c == 3, on && c == 0, lim && (c == 1 + ($urandom % 3)), th, "R3");
        end
        if (th_left > 0) th_left--;
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule